// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter and Buffer

This block sits behind the serial receiver of one ARINC 429 channel. Each time the receiver completes a 32-bit word it presents the word with a one-cycle strobe. The block can mark the parity result in bit 32. It then decides whether to keep the word. One test compares the 8-bit label against a 16-entry table. The other compares ARINC bits 10 and 9 against two programmed values. Either test can be turned off. A kept word enters a four-word receive buffer.

The host drains the buffer one word at a time with a pop request. The head word is always visible on the read port, and the read port shows zero when the buffer is empty. When the buffer is full, a new word replaces the newest stored entry, so the older words are kept. Registered empty and full outputs report the buffer state. One interrupt flag follows either not-empty or full, as selected. On readout the label field can be shown in received bit order or reversed.

The control register itself is held outside the block. The block only sees its bits and a strobe that marks each write to it.

Top module: `arinc_rx_filter`

## Requirements
- R1: The label table has 16 entries of 8 bits. Entries are written by index and read back combinationally by index. Table entry bit 7 is compared with ARINC bit 1, which is `word_in[0]`, and entry bit 0 is compared with ARINC bit 8, which is `word_in[7]`.
- R2: With `cfg_lbl_en`=1, a word is kept only if its label equals at least one table entry. A label of 00h matches like any other value. A word that is not kept leaves the buffer unchanged.
- R3: With `cfg_lbl_en`=0, every label passes the label test.
- R4: With `cfg_dec_en`=1, a word is kept only if ARINC bit 10 (`word_in[9]`) equals `cfg_dec_b10` and ARINC bit 9 (`word_in[8]`) equals `cfg_dec_b9`. A word is stored only when every enabled test passes.
- R5: With `cfg_par_en`=1, a word whose 32 bits hold an odd number of ones is stored with bit 32 (`word_in[31]`) cleared. Any other word is stored unchanged, and with `cfg_par_en`=0 all 32 bits are stored as received.
- R6: The buffer holds 4 words and returns them in arrival order. When it is full and no pop occurs, a newly kept word replaces the most recently stored entry.
- R7: `rd_word` shows the head entry and reads all zeros when the buffer is empty. A pop on an empty buffer has no effect.
- R8: If a pop and a kept word occur in the same cycle, the pop is applied first and the push second. A full buffer therefore loses no entry in that case.
- R9: `empty` and `full` are registered. They change at the clock edge that performs the push or pop which changes them.
- R10: `flag` equals not-empty when `cfg_flag_full`=0 and equals `full` when `cfg_flag_full`=1.
- R11: A `cfg_wr` strobe, the master reset `rst`, and `cfg_chan_rst`=1 each empty the buffer. While `cfg_chan_rst` is 1, no word is stored.
- R12: With `cfg_lbl_fwd`=1, `rd_word[7:0]` shows the label in received order. With `cfg_lbl_fwd`=0, those eight bits are reversed. All other bits are unchanged, and label matching does not depend on this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high; clears the buffer |
| word_vld | input | 1 | One-cycle strobe: `word_in` holds a completed word |
| word_in | input | 32 | Received word; ARINC bit n is at index n-1 |
| cfg_flag_full | input | 1 | Flag source: 0 = not-empty, 1 = full |
| cfg_lbl_en | input | 1 | Enable the label test |
| cfg_chan_rst | input | 1 | Channel reset; holds the buffer empty |
| cfg_par_en | input | 1 | Enable parity marking in bit 32 |
| cfg_dec_en | input | 1 | Enable the bit 10/9 test |
| cfg_dec_b10 | input | 1 | Required value of ARINC bit 10 |
| cfg_dec_b9 | input | 1 | Required value of ARINC bit 9 |
| cfg_lbl_fwd | input | 1 | Label order on readout: 1 = as received, 0 = reversed |
| cfg_wr | input | 1 | Strobe marking a control register write; clears the buffer |
| lbl_we | input | 1 | Label table write enable |
| lbl_widx | input | 4 | Label table write index |
| lbl_wdata | input | 8 | Label table write data |
| lbl_ridx | input | 4 | Label table read index |
| lbl_rdata | output | 8 | Label table read data |
| pop | input | 1 | Remove the head word |
| rd_word | output | 32 | Head word with label reordering applied; zero when empty |
| empty | output | 1 | Buffer empty (registered) |
| full | output | 1 | Buffer full (registered) |
| flag | output | 1 | Interrupt flag selected by `cfg_flag_full` |

## Verification
A broken fill count shows at the ports within one clock: `empty` or `full` takes the wrong value at the edge after a push or pop. A wrong read or write pointer only shows when the host drains the buffer. The bench therefore pops every stored word and compares the data in order, including after an overwrite when full. The filter decisions show up as a missing or unexpected stored word, at the latest when the buffer is drained. The bench compares each pop against a scoreboard model built from the requirements.

// File: rtl/arinc_filt_pkg.sv
package arinc_filt_pkg;

    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;

    // Buffer operation chosen in one cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_BOTH,
        OP_OVWR
    } buf_op_e;

    // Control bits that steer the accept decision
    typedef struct packed {
        logic lbl_en;
        logic par_en;
        logic dec_en;
        logic dec_b10;
        logic dec_b9;
        logic chan_rst;
    } gate_cfg_t;

    function automatic logic [LBL_W-1:0] flip_label(input logic [LBL_W-1:0] l);
        logic [LBL_W-1:0] r;
        for (int i = 0; i < LBL_W; i++) r[i] = l[LBL_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/label_table.sv
module label_table
    import arinc_filt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [LBL_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [LBL_W-1:0] rdata,
    input  logic [LBL_W-1:0] rx_label,   // ARINC bits 1..8 at [0]..[7]
    output logic             hit
);

    logic [LBL_W-1:0] tbl [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [LBL_W-1:0] cmp_label;

    // entry MSB compares with the first label bit received
    assign cmp_label = flip_label(rx_label);

    always_ff @(posedge clk) begin
        if (we) tbl[widx] <= wdata;
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign hit_vec[e] = (tbl[e] == cmp_label);
        end
    endgenerate

    assign hit   = |hit_vec;
    assign rdata = tbl[ridx];

endmodule

// File: rtl/word_gate.sv
module word_gate
    import arinc_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  gate_cfg_t         cfg,
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    input  logic              lbl_hit,
    output logic              push,
    output logic [WORD_W-1:0] store_word
);

    logic lbl_ok, dec_ok, odd_ones;

    assign odd_ones = ^word;
    assign lbl_ok   = !cfg.lbl_en || lbl_hit;
    assign dec_ok   = !cfg.dec_en || ((word[9] == cfg.dec_b10) && (word[8] == cfg.dec_b9));
    assign push     = vld && !cfg.chan_rst && lbl_ok && dec_ok;

    always_comb begin
        store_word = word;
        if (cfg.par_en && odd_ones) store_word[WORD_W-1] = 1'b0;
    end

    // R4
    decode_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.dec_en && (word[9] != cfg.dec_b10)) |-> !push);

    // R5
    parity_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (push && cfg.par_en && odd_ones) |-> !store_word[WORD_W-1]);

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import arinc_filt_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    buf_op_e          op;

    always_comb begin
        op = OP_IDLE;
        unique case ({push, pop && !empty})
            2'b10:   op = full ? OP_OVWR : OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_BOTH;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        cnt_nxt = cnt;
        if (op == OP_PUSH) cnt_nxt = cnt + 1'b1;
        else if (op == OP_POP) cnt_nxt = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            empty <= (cnt_nxt == '0);
            full  <= (cnt_nxt == CNT_W'(DEPTH));
            case (op)
                OP_PUSH: begin
                    mem[wptr] <= din;
                    wptr      <= wptr + 1'b1;
                end
                OP_POP:  rptr <= rptr + 1'b1;
                OP_BOTH: begin
                    mem[wptr] <= din;
                    wptr      <= wptr + 1'b1;
                    rptr      <= rptr + 1'b1;
                end
                OP_OVWR: mem[wptr - 1'b1] <= din;
                default: ;
            endcase
        end
    end

    assign dout = empty ? '0 : mem[rptr];

    // R6
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (full && push && !pop) |=> (full && $stable(wptr) && $stable(rptr)));

    // R7
    empty_pop_inert_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (empty && pop && !push) |=> (empty && $stable(rptr)));

    // R8
    both_keeps_count_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (push && pop && !empty) |=> $stable(cnt));

    // R9
    status_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

endmodule

// File: rtl/arinc_rx_filter.sv
module arinc_rx_filter
    import arinc_filt_pkg::*;
#(
    parameter int N_LABELS = 16,
    parameter int DEPTH    = 4,
    localparam int IDX_W   = $clog2(N_LABELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [31:0]       word_in,
    input  logic              cfg_flag_full,
    input  logic              cfg_lbl_en,
    input  logic              cfg_chan_rst,
    input  logic              cfg_par_en,
    input  logic              cfg_dec_en,
    input  logic              cfg_dec_b10,
    input  logic              cfg_dec_b9,
    input  logic              cfg_lbl_fwd,
    input  logic              cfg_wr,
    input  logic              lbl_we,
    input  logic [IDX_W-1:0]  lbl_widx,
    input  logic [7:0]        lbl_wdata,
    input  logic [IDX_W-1:0]  lbl_ridx,
    output logic [7:0]        lbl_rdata,
    input  logic              pop,
    output logic [31:0]       rd_word,
    output logic              empty,
    output logic              full,
    output logic              flag
);

    gate_cfg_t         gcfg;
    logic              lbl_hit, push;
    logic [WORD_W-1:0] store_word, head;

    assign gcfg = '{lbl_en:   cfg_lbl_en,
                    par_en:   cfg_par_en,
                    dec_en:   cfg_dec_en,
                    dec_b10:  cfg_dec_b10,
                    dec_b9:   cfg_dec_b9,
                    chan_rst: cfg_chan_rst};

    label_table #(.ENTRIES(N_LABELS)) u_tbl (
        .clk      (clk),
        .we       (lbl_we),
        .widx     (lbl_widx),
        .wdata    (lbl_wdata),
        .ridx     (lbl_ridx),
        .rdata    (lbl_rdata),
        .rx_label (word_in[LBL_W-1:0]),
        .hit      (lbl_hit)
    );

    word_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cfg        (gcfg),
        .vld        (word_vld),
        .word       (word_in),
        .lbl_hit    (lbl_hit),
        .push       (push),
        .store_word (store_word)
    );

    rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_wr || cfg_chan_rst),
        .push  (push),
        .din   (store_word),
        .pop   (pop),
        .dout  (head),
        .empty (empty),
        .full  (full)
    );

    always_comb begin
        rd_word = head;
        if (!cfg_lbl_fwd) rd_word[LBL_W-1:0] = flip_label(head[LBL_W-1:0]);
    end

    assign flag = cfg_flag_full ? full : !empty;

    // R11
    chan_rst_empties_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_chan_rst |=> empty);

    // R11
    cfg_wr_empties_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> empty);

    // R7
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (rd_word == '0));

endmodule

// File: tb/arinc_rx_filter_tb.sv
module arinc_rx_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic [31:0] word_in = '0;
    logic        cfg_flag_full = 1'b0, cfg_lbl_en = 1'b0, cfg_chan_rst = 1'b0;
    logic        cfg_par_en = 1'b0, cfg_dec_en = 1'b0, cfg_dec_b10 = 1'b0;
    logic        cfg_dec_b9 = 1'b0, cfg_lbl_fwd = 1'b1, cfg_wr = 1'b0;
    logic        lbl_we = 1'b0;
    logic [3:0]  lbl_widx = '0, lbl_ridx = '0;
    logic [7:0]  lbl_wdata = '0, lbl_rdata;
    logic        pop = 1'b0;
    logic [31:0] rd_word;
    logic        empty, full, flag;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [31:0] sb[$];      // scoreboard: words expected in the buffer
    logic [7:0]  tbl_m [16];

    always #4 clk = ~clk;

    arinc_rx_filter u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // expected model of the accept decision
    function automatic bit keeps(input logic [31:0] w);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (tbl_m[i] == rev8(w[7:0])) hit = 1;
        if (cfg_chan_rst) return 0;
        if (cfg_lbl_en && !hit) return 0;
        if (cfg_dec_en && (w[9] != cfg_dec_b10 || w[8] != cfg_dec_b9)) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] stored(input logic [31:0] w);
        logic [31:0] s = w;
        if (cfg_par_en && ^w) s[31] = 1'b0;
        return s;
    endfunction

    function automatic logic [31:0] shown(input logic [31:0] s);
        logic [31:0] r = s;
        if (!cfg_lbl_fwd) r[7:0] = rev8(s[7:0]);
        return r;
    endfunction

    // driver: presents a word and updates the scoreboard
    task automatic send(input logic [31:0] w, input bit with_pop = 0);
        @(negedge clk);
        word_vld = 1'b1;
        word_in  = w;
        pop      = with_pop;
        if (with_pop) begin
            chk("R8 head before pop", rd_word, sb.size() ? shown(sb[0]) : 32'h0);
            if (sb.size()) void'(sb.pop_front());
        end
        if (keeps(w)) begin
            if (sb.size() == 4) sb[3] = stored(w);
            else sb.push_back(stored(w));
        end
        @(posedge clk);
        #1;
        word_vld = 1'b0;
        pop      = 1'b0;
    endtask

    // monitor: takes the head word and compares with the scoreboard
    task automatic take(input string tag);
        @(negedge clk);
        chk(tag, rd_word, sb.size() ? shown(sb[0]) : 32'h0);
        if (sb.size()) void'(sb.pop_front());
        pop = 1'b1;
        @(posedge clk);
        #1;
        pop = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (sb.size()) take(tag);
        @(negedge clk);
        chk({tag, " empty after drain"}, empty, 1'b1);
    endtask

    task automatic set_label(input int idx, input logic [7:0] v);
        @(negedge clk);
        lbl_we = 1'b1; lbl_widx = 4'(idx); lbl_wdata = v;
        tbl_m[idx] = v;
        @(posedge clk);
        #1;
        lbl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 R7 reset state
        chk("R9 reset empty", empty, 1'b1);
        chk("R9 reset full", full, 1'b0);
        chk("R7 reset read zero", rd_word, 32'h0);
        chk("R10 reset flag", flag, 1'b0);

        // R1 table load and readback
        for (int i = 0; i < 16; i++) set_label(i, 8'h31);
        set_label(5, 8'hA6);
        set_label(9, 8'h00);
        @(negedge clk);
        lbl_ridx = 4'd5; #1;
        chk("R1 table read", {24'h0, lbl_rdata}, 32'hA6);

        // R9 R10 R3: label test off, push timing
        @(negedge clk);
        word_vld = 1'b1; word_in = 32'h1234_5601;
        sb.push_back(32'h1234_5601);
        #1 chk("R9 empty before edge", empty, 1'b1);
        @(posedge clk); #1 word_vld = 1'b0;
        chk("R9 empty after edge", empty, 1'b0);
        chk("R10 flag not-empty mode", flag, 1'b1);
        send(32'h0000_00FF);
        drain("R3 any label kept");

        // R12 reversed label readout
        cfg_lbl_fwd = 1'b0;
        send(32'hCAFE_0013);
        drain("R12 reversed label");
        cfg_lbl_fwd = 1'b1;

        // R1 R2 label test on
        cfg_lbl_en = 1'b1;
        send({24'h0ABCDE, rev8(8'hA6)});      // matches entry 5
        send({24'h111111, rev8(8'h77)});      // no match
        send({24'h222222, 8'h00});            // matches 00h
        send({24'h333333, 8'hA6});            // wrong order: no match
        chk("R2 two kept", 32'(sb.size()), 32'd2);
        drain("R2 label filter");

        // R12 matching is unaffected by readout order
        cfg_lbl_fwd = 1'b0;
        send({24'h444444, rev8(8'hA6)});
        drain("R12 match independent of order");
        cfg_lbl_fwd = 1'b1;
        cfg_lbl_en = 1'b0;

        // R4 decoder
        cfg_dec_en = 1'b1; cfg_dec_b10 = 1'b1; cfg_dec_b9 = 1'b0;
        send(32'h0000_0200);                  // b10=1 b9=0 pass
        send(32'h0000_0100);                  // fail
        send(32'h0000_0300);                  // fail
        chk("R4 one kept", 32'(sb.size()), 32'd1);
        drain("R4 decoder");
        cfg_dec_en = 1'b0;

        // R5 parity marking
        cfg_par_en = 1'b1;
        send(32'h8000_0000);                  // odd -> bit32 cleared
        send(32'h8000_0001);                  // even -> unchanged
        drain("R5 parity on");
        cfg_par_en = 1'b0;
        send(32'h8000_0000);
        drain("R5 parity off");

        // R6 R10 fill and overwrite
        cfg_flag_full = 1'b1;
        for (int i = 0; i < 4; i++) send(32'h1000_0000 + i);
        @(negedge clk);
        chk("R6 full at four", full, 1'b1);
        chk("R10 flag full mode", flag, 1'b1);
        send(32'h5555_AAAA);                  // overwrites newest
        // R8 pop and push together while full
        send(32'h6666_0000, 1);
        @(negedge clk);
        chk("R8 still full", full, 1'b1);
        take("R6 order after overwrite");
        @(negedge clk);
        chk("R9 full drops", full, 1'b0);
        chk("R10 flag off below full", flag, 1'b0);
        drain("R6 drain");
        cfg_flag_full = 1'b0;

        // R7 pop on empty
        take("R7 empty pop");
        @(negedge clk);
        chk("R7 still empty", empty, 1'b1);

        // R11 clears
        send(32'hABCD_0001);
        @(negedge clk); cfg_wr = 1'b1;
        @(posedge clk); #1 cfg_wr = 1'b0;
        sb.delete();
        @(negedge clk);
        chk("R11 cfg write clears", empty, 1'b1);
        @(negedge clk); cfg_chan_rst = 1'b1;
        send(32'hABCD_0002);
        @(negedge clk);
        chk("R11 chan reset blocks", empty, 1'b1);
        cfg_chan_rst = 1'b0;
        send(32'hABCD_0003);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        sb.delete();
        @(negedge clk);
        chk("R11 master reset clears", empty, 1'b1);
        send(32'hABCD_0004);
        drain("R11 works after reset");

        finish_run();
    end

endmodule